// File: doc/BRIEF.md
# CAN Identifier Arbitration Unit

This block is the transmit-side arbitration engine of a CAN node, covering only the identifier field. A request loads an identifier and a frame-format select. The unit then waits until the bus has been recessive long enough to count as idle. It drives a dominant start-of-frame bit and then shifts the identifier out, most significant bit first, with one bit per bit-time strobe.

The sampled bus level is fed back in on every strobe. While the unit drives recessive and reads back dominant, a node with a numerically lower identifier is still on the bus. The unit then records the bit position where that happened, stops transmitting and releases the line to recessive. If every identifier bit passes without such a conflict, it raises a won flag and releases the line, leaving the rest of the frame to downstream logic. If the unit drives dominant and reads back recessive, that is reported on a separate bit-error flag and does not count as a loss.

The unit does not handle bit stuffing, the CRC, the fields after the identifier, or bit timing. The strobe marks the sample point and comes from outside.

Top module: `can_arb_unit`

## Requirements
- R1: While reset is held and after it is released, tx_bit is 1 (recessive) and arb_lost, arb_won, bit_err and lost_idx are all 0.
- R2: A one-cycle start_req is accepted only when no request is pending and no arbitration is running. On acceptance the unit captures ident and ext_sel. A start_req that arrives while waiting for idle or while arbitrating is ignored, and later changes on ident do not alter the bits that are sent.
- R3: Bus idle means 11 consecutive recessive samples, with one sample taken on each bit_tick. A dominant sample restarts the count. tx_bit goes to 0 (start of frame) on the clock edge of the strobe that takes the 11th consecutive recessive sample of a pending request. Before that edge, tx_bit stays 1.
- R4: After the start-of-frame bit time, one identifier bit is sent per strobe, starting from the MSB. With ext_sel=0 the unit sends ident[10:0] and ignores ident[28:11]. With ext_sel=1 it sends ident[28:0].
- R5: On a strobe where the unit sends 1 and samples 0 during an identifier bit, arb_lost goes to 1 and lost_idx takes that bit's position (10..0 or 28..0). tx_bit stays 1 from then on.
- R6: Sampling the same level that was sent is never a loss, and dominant read back on a dominant bit lets the unit continue to the next bit.
- R7: Sending 0 and sampling 1, during start of frame or an identifier bit, sets bit_err and not arb_lost. Transmission carries on.
- R8: arb_won goes to 1 after the strobe of identifier bit 0 if no loss has occurred, and tx_bit then returns to 1. arb_won and arb_lost are never both 1.
- R9: arb_lost, arb_won, bit_err and lost_idx hold their values until the next accepted start_req, which clears them.
- R10: Against a competing node on a wired-AND bus, the unit wins when its identifier is numerically lower or equal. Otherwise it loses at the highest bit where the two identifiers differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle strobe at each bit's sample point |
| start_req | input | 1 | One-cycle request to arbitrate |
| ident | input | 29 | Identifier; the low 11 bits are used for standard format |
| ext_sel | input | 1 | 1 selects the 29-bit identifier, 0 the 11-bit identifier |
| rx_bit | input | 1 | Sampled bus level (0 dominant, 1 recessive) |
| tx_bit | output | 1 | Transmitted level (0 dominant, 1 recessive) |
| arb_lost | output | 1 | Arbitration lost, held until the next request |
| lost_idx | output | 5 | Identifier bit position where arbitration was lost |
| arb_won | output | 1 | All identifier bits sent with no loss |
| bit_err | output | 1 | Dominant sent but recessive sampled |

## Verification
Each result is registered once. tx_bit, arb_lost, lost_idx, arb_won and bit_err all take their new value on the clock edge where bit_tick is high, so they are due one cycle after the strobe. The bench drives rx_bit and bit_tick on a falling edge and drops the strobe on the next falling edge, where it also samples the outputs. It then idles two more cycles before the next bit, which keeps every check in that single-cycle window. Accepting a request also takes effect on the next edge, so the clearing of the flags is checked one falling edge after the start_req pulse.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_SOF  = 3'd2,
    ST_ID   = 3'd3,
    ST_DONE = 3'd4
  } arb_state_t;

endpackage

// File: rtl/can_arb_rst_sync.sv
module can_arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/can_arb_idle_det.sv
module can_arb_idle_det #(
  parameter int IDLE_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_bit,
  output logic idle_ok
);

  localparam int CNT_W = $clog2(IDLE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_LEN);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(IDLE_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // count consecutive recessive samples, saturating at IDLE_LEN
  assign cnt_en = bit_tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!rx_bit) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // this strobe's sample completes the idle run
  assign idle_ok = rx_bit && (cnt_q >= CNT_LIM);

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  a_r3_dominant_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !rx_bit) |=> (cnt_q == '0));

endmodule

// File: rtl/can_arb_ctrl.sv
module can_arb_ctrl
  import can_arb_pkg::*;
#(
  parameter int STD_W = 11,
  parameter int EXT_W = 29,
  parameter int IDX_W = $clog2(EXT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             start_req,
  input  logic [EXT_W-1:0] ident,
  input  logic             ext_sel,
  input  logic             rx_bit,
  input  logic             idle_ok,
  output logic             tx_bit,
  output logic             arb_lost,
  output logic [IDX_W-1:0] lost_idx,
  output logic             arb_won,
  output logic             bit_err
);

  localparam logic [IDX_W-1:0] STD_MSB = IDX_W'(STD_W - 1);
  localparam logic [IDX_W-1:0] EXT_MSB = IDX_W'(EXT_W - 1);

  arb_state_t       state_q, state_d;
  logic [EXT_W-1:0] id_q, id_d;
  logic             ext_q, ext_d;
  logic [IDX_W-1:0] idx_q, idx_d, idx_nx, msb_sel;
  logic             tx_q, tx_d;
  logic             lost_q, lost_d;
  logic [IDX_W-1:0] lidx_q, lidx_d;
  logic             won_q, won_d;
  logic             err_q, err_d;
  logic             conflict, dom_miss;

  assign msb_sel  = ext_q ? EXT_MSB : STD_MSB;
  assign idx_nx   = idx_q - 1'b1;
  assign conflict = tx_q && !rx_bit;
  assign dom_miss = !tx_q && rx_bit;

  always_comb begin
    state_d = state_q;
    id_d    = id_q;
    ext_d   = ext_q;
    idx_d   = idx_q;
    tx_d    = tx_q;
    lost_d  = lost_q;
    lidx_d  = lidx_q;
    won_d   = won_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_req) begin
          state_d = ST_WAIT;
          id_d    = ident;
          ext_d   = ext_sel;
          lost_d  = 1'b0;
          lidx_d  = '0;
          won_d   = 1'b0;
          err_d   = 1'b0;
          tx_d    = 1'b1;
        end
      end
      ST_WAIT: begin
        if (bit_tick && idle_ok) begin
          state_d = ST_SOF;
          tx_d    = 1'b0;
        end
      end
      ST_SOF: begin
        if (bit_tick) begin
          if (dom_miss) err_d = 1'b1;
          state_d = ST_ID;
          idx_d   = msb_sel;
          tx_d    = id_q[msb_sel];
        end
      end
      ST_ID: begin
        if (bit_tick) begin
          if (conflict) begin
            lost_d  = 1'b1;
            lidx_d  = idx_q;
            tx_d    = 1'b1;
            state_d = ST_DONE;
          end else begin
            if (dom_miss) err_d = 1'b1;
            if (idx_q == '0) begin
              won_d   = 1'b1;
              tx_d    = 1'b1;
              state_d = ST_DONE;
            end else begin
              idx_d = idx_nx;
              tx_d  = id_q[idx_nx];
            end
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        tx_d    = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      id_q    <= '0;
      ext_q   <= 1'b0;
      idx_q   <= '0;
      tx_q    <= 1'b1;
      lost_q  <= 1'b0;
      lidx_q  <= '0;
      won_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      id_q    <= id_d;
      ext_q   <= ext_d;
      idx_q   <= idx_d;
      tx_q    <= tx_d;
      lost_q  <= lost_d;
      lidx_q  <= lidx_d;
      won_q   <= won_d;
      err_q   <= err_d;
    end
  end

  assign tx_bit   = tx_q;
  assign arb_lost = lost_q;
  assign lost_idx = lidx_q;
  assign arb_won  = won_q;
  assign bit_err  = err_q;

  a_r3_wait_holds_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !(bit_tick && idle_ok)) |=> tx_bit);

  a_r5_loss_on_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && state_q == ST_ID && tx_q && !rx_bit) |=> (arb_lost && tx_bit));

  a_r5_released_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> tx_bit);

  a_r6_match_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && state_q == ST_ID && (tx_q == rx_bit)) |=> !arb_lost);

  a_r7_error_not_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && (state_q == ST_SOF || state_q == ST_ID) && !tx_q && rx_bit)
      |=> (bit_err && !arb_lost));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(arb_won && arb_lost));

  a_r8_won_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    arb_won |-> tx_bit);

  a_r9_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !start_req) |=> (arb_lost && $stable(lost_idx)));

  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (lost_idx <= EXT_MSB));

endmodule

// File: rtl/can_arb_unit.sv
module can_arb_unit #(
  parameter int STD_W    = 11,
  parameter int EXT_W    = 29,
  parameter int IDLE_LEN = 11,
  parameter int IDX_W    = $clog2(EXT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             start_req,
  input  logic [EXT_W-1:0] ident,
  input  logic             ext_sel,
  input  logic             rx_bit,
  output logic             tx_bit,
  output logic             arb_lost,
  output logic [IDX_W-1:0] lost_idx,
  output logic             arb_won,
  output logic             bit_err
);

  logic rst_n_sync;
  logic idle_ok;

  can_arb_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  can_arb_idle_det #(.IDLE_LEN(IDLE_LEN)) u_idle_det (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .bit_tick (bit_tick),
    .rx_bit   (rx_bit),
    .idle_ok  (idle_ok)
  );

  can_arb_ctrl #(
    .STD_W (STD_W),
    .EXT_W (EXT_W),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .bit_tick  (bit_tick),
    .start_req (start_req),
    .ident     (ident),
    .ext_sel   (ext_sel),
    .rx_bit    (rx_bit),
    .idle_ok   (idle_ok),
    .tx_bit    (tx_bit),
    .arb_lost  (arb_lost),
    .lost_idx  (lost_idx),
    .arb_won   (arb_won),
    .bit_err   (bit_err)
  );

endmodule

// File: tb/can_arb_unit_tb.sv
`timescale 1ns/1ps
module can_arb_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        bit_tick;
  logic        start_req;
  logic [28:0] ident;
  logic        ext_sel;
  logic        rx_bit;
  logic        tx_bit;
  logic        arb_lost;
  logic [4:0]  lost_idx;
  logic        arb_won;
  logic        bit_err;

  int n_checks = 0;
  int n_fails  = 0;

  can_arb_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .start_req (start_req),
    .ident     (ident),
    .ext_sel   (ext_sel),
    .rx_bit    (rx_bit),
    .tx_bit    (tx_bit),
    .arb_lost  (arb_lost),
    .lost_idx  (lost_idx),
    .arb_won   (arb_won),
    .bit_err   (bit_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one bit time: strobe with the given bus level, sample one cycle later
  task automatic bit_time(input logic level);
    @(negedge clk);
    rx_bit   = level;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic pause2();
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  function automatic int first_diff(input logic [28:0] a, input logic [28:0] b,
                                    input int msb);
    for (int i = msb; i >= 0; i--) begin
      if (a[i] != b[i]) return i;
    end
    return -1;
  endfunction

  // request, gate on idle, send SOF and identifier against a competing node
  task automatic run_arb(input string name, input logic [28:0] ours,
                         input logic [28:0] other, input logic ext,
                         input int err_idx, input int gap, input bit midstart);
    int          msb;
    logic        lost_m;
    logic        oth_lost;
    logic        txe;
    logic        ob;
    logic        rx_v;
    logic [28:0] mask;
    bit          exp_win;
    msb      = ext ? 28 : 10;
    mask     = ext ? 29'h1FFF_FFFF : 29'h0000_07FF;
    lost_m   = 1'b0;
    oth_lost = 1'b0;
    ident    = ours;
    ext_sel  = ext;
    pulse_start();
    // R9: flags cleared by the accepted request
    check(!arb_lost && !arb_won && !bit_err && lost_idx == 0, "R9",
          {name, " flags cleared on start"},
          {arb_lost, arb_won, bit_err}, 0);
    // R2: later changes on ident must not matter
    ident   = ~ours;
    ext_sel = ~ext;
    pause2();
    bit_time(1'b0);
    pause2();
    if (gap > 0) begin
      for (int k = 0; k < gap; k++) begin
        bit_time(1'b1);
        check(tx_bit == 1'b1, "R3", {name, " recessive before gap dominant"}, tx_bit, 1);
        pause2();
      end
      bit_time(1'b0);
      check(tx_bit == 1'b1, "R3", {name, " dominant restarts idle count"}, tx_bit, 1);
      pause2();
    end
    for (int k = 1; k <= 11; k++) begin
      bit_time(1'b1);
      if (k < 11) begin
        if (tx_bit != 1'b1)
          check(1'b0, "R3", {name, " SOF before idle"}, tx_bit, 1);
      end else begin
        check(tx_bit == 1'b0, "R3", {name, " SOF after 11 recessive"}, tx_bit, 0);
      end
      pause2();
    end
    // start of frame bit time, competitor also dominant
    bit_time(1'b0);
    pause2();
    for (int i = msb; i >= 0; i--) begin
      txe = lost_m ? 1'b1 : ours[i];
      if (tx_bit !== txe)
        check(1'b0, "R4", {name, " identifier bit"}, tx_bit, txe);
      else
        n_checks++;
      if (midstart && i == msb - 3) begin
        ident = 29'h0;
        pulse_start();
      end
      ob   = oth_lost ? 1'b1 : other[i];
      rx_v = (i == err_idx) ? 1'b1 : (tx_bit & ob);
      bit_time(rx_v);
      if (ob && !rx_v) oth_lost = 1'b1;
      if (!lost_m && txe && !rx_v) begin
        lost_m = 1'b1;
        check(arb_lost && lost_idx == i && tx_bit, "R5",
              {name, " loss index"}, lost_idx, i);
      end else if (!lost_m) begin
        if (arb_lost) check(1'b0, "R6", {name, " false loss"}, arb_lost, 0);
      end
      pause2();
    end
    exp_win = (ours & mask) <= (other & mask);
    check(arb_won == exp_win, "R10", {name, " won flag"}, arb_won, exp_win);
    check(arb_lost == !exp_win, "R8", {name, " lost flag"}, arb_lost, !exp_win);
    if (!exp_win) begin
      check(lost_idx == first_diff(ours & mask, other & mask, msb), "R10",
            {name, " loss at highest differing bit"}, lost_idx,
            first_diff(ours & mask, other & mask, msb));
    end
    check(bit_err == (err_idx >= 0), "R7", {name, " bit error flag"}, bit_err, err_idx >= 0);
    check(tx_bit == 1'b1, "R8", {name, " released after identifier"}, tx_bit, 1);
    bit_time(1'b0);
    check(arb_won == exp_win && arb_lost == !exp_win && bit_err == (err_idx >= 0),
          "R9", {name, " flags hold"}, {arb_won, arb_lost}, {exp_win, !exp_win});
    pause2();
  endtask

  task automatic t_reset();
    check(tx_bit == 1'b1, "R1", "tx after reset", tx_bit, 1);
    check(!arb_lost && !arb_won && !bit_err, "R1", "flags after reset",
          {arb_lost, arb_won, bit_err}, 0);
    check(lost_idx == 0, "R1", "lost_idx after reset", lost_idx, 0);
  endtask

  task automatic t_no_request();
    for (int k = 0; k < 14; k++) begin
      bit_time(1'b1);
      pause2();
    end
    check(tx_bit == 1'b1, "R2", "no SOF without request", tx_bit, 1);
  endtask

  initial begin
    rst_n = 1'b0; bit_tick = 1'b0; start_req = 1'b0;
    ident = '0; ext_sel = 1'b0; rx_bit = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_bit == 1'b1 && !arb_won, "R1", "during reset", tx_bit, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_request();
    run_arb("std_win",    29'h1FFF_F122, 29'h0000_0123, 1'b0, -1, 0, 1'b0);
    run_arb("std_lose0",  29'h0000_0123, 29'h0000_0122, 1'b0, -1, 0, 1'b0);
    run_arb("std_losemsb",29'h0000_07FF, 29'h0000_03FF, 1'b0, -1, 6, 1'b0);
    run_arb("ext_lose15", 29'h1ABC_DE55, 29'h1ABC_0E55, 1'b1, -1, 0, 1'b1);
    run_arb("ext_win",    29'h0000_1000, 29'h1FFF_FFFF, 1'b1, -1, 3, 1'b0);
    run_arb("equal_ids",  29'h0000_02A5, 29'h0000_02A5, 1'b0, -1, 0, 1'b1);
    run_arb("bit_error",  29'h0000_02A5, 29'h0000_02A5, 1'b0, 10, 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule